// File: doc/BRIEF.md
# Power-of-Two Aligned Entry Allocator

This block tracks which slots of a remapping table are in use, one occupancy bit per slot. A client asks for a number of slots. The block rounds that number up to a power of two and looks for a free block of that size that starts on a boundary of the same size. It returns the base slot and the size exponent, or it returns a failure flag. A client frees a block by giving its base and exponent. Single slots can be marked used one at a time, so a table inherited from an earlier configuration can be rebuilt from its present bits. A combinational flag reports when no slot is in use. Higher layers use that flag to refuse removal of the unit.

The search tests one aligned candidate base per clock, starting at zero and going upward, and takes the lowest candidate that fits. While a search runs, `req_ready` is low and the block accepts no request. Every result comes with a one-cycle `done` pulse. The base, exponent and failure flag stay valid until the next result.

Top module: `pow2_entry_alloc`

## Requirements
- R1: An allocation request whose count is 0 produces `done` with `fail`=1 on the cycle after acceptance, and the occupancy is unchanged.
- R2: A count greater than one is rounded up to the next power of two. On success, `res_mask` is log2 of the rounded size; a count of 1 gives exponent 0.
- R3: If the size exponent is greater than the parameter `MAX_MASK`, the request fails on the cycle after acceptance and no search is made.
- R4: A successful base is a multiple of 2^mask, and every slot in the block was free before the allocation. The base is the lowest aligned candidate that fits. Candidate k (base = k·2^mask) is reported `done` k+2 falling edges after the accepting edge.
- R5: If no aligned candidate is completely free, the request ends with `done` and `fail`=1 after the last candidate.
- R6: A release with base b and exponent m clears exactly the slots b through b+2^m−1 and no other slot.
- R7: A mark request with index i sets slot i as used and changes no other slot.
- R8: `empty` is 1 exactly when no slot is in use.
- R9: From the edge that accepts a searching allocation until the result, `req_ready` is 0 and `busy` is 1. No request is accepted in that time.
- R10: After reset, the table is empty, `req_ready` is 1, and `busy` and `done` are 0.
- R11: When several requests are valid in the same accepted cycle, allocate takes priority over release, and release takes priority over mark. The requests that lose are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_ready | output | 1 | Requests are accepted in this cycle |
| alloc_valid | input | 1 | Allocation request |
| alloc_count | input | CW | Requested slot count |
| rel_valid | input | 1 | Release request |
| rel_base | input | IDXW | Base slot to release |
| rel_mask | input | MW | Size exponent to release |
| mark_valid | input | 1 | Mark-one-slot request |
| mark_idx | input | IDXW | Slot to mark used |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| fail | output | 1 | Last allocation failed |
| res_base | output | IDXW | Base of the last allocation |
| res_mask | output | MW | Exponent of the last allocation |
| empty | output | 1 | No slot is in use |

## Verification
The bench models the occupancy itself and works out the lowest aligned free base for every request. Getting the order of the search or the alignment wrong would show up as a wrong base. Requests for a count of zero and for a size above the limit have to fail at once. A design that searched anyway would be late or would report success. Once slot 16 is preloaded, the 8-slot request has to skip to slot 24, and a later 8-slot request has to fail after a full scan. A design that missed the preload or miscounted the step would hand out slots that are already in use. The bench checks that releases free exactly their block, that the empty flag follows the model, that ready is low during a search, and that requests are dropped by priority when several arrive together.

// File: rtl/pea_pkg.sv
package pea_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_SRCH = 1'b1} pea_state_t;
endpackage

// File: rtl/pea_size_dec.sv
module pea_size_dec #(
  parameter int CW = 6,
  parameter int MW = 3
) (
  input  logic [CW-1:0] count,
  output logic [MW-1:0] mask,
  output logic          zero
);
  always_comb begin
    zero = (count == '0);
    mask = '0;
    for (int m = CW; m >= 0; m--) begin
      if (((CW+1)'(1) << m) >= {1'b0, count}) mask = MW'(m);
    end
  end
endmodule

// File: rtl/pea_window.sv
module pea_window #(
  parameter int N  = 32,
  parameter int EW = 7,
  parameter int MW = 3
) (
  input  logic [EW-1:0] base,
  input  logic [MW-1:0] mask,
  output logic [N-1:0]  win
);
  logic [EW-1:0] lim;
  assign lim = base + (EW'(1) << mask);

  for (genvar gi = 0; gi < N; gi++) begin : g_bit
    assign win[gi] = (EW'(gi) >= base) && (EW'(gi) < lim);
  end
endmodule

// File: rtl/pow2_entry_alloc.sv
module pow2_entry_alloc
  import pea_pkg::*;
#(
  parameter int ENTRIES  = 32,
  parameter int MAX_MASK = 3,
  localparam int IDXW = $clog2(ENTRIES),
  localparam int CW   = IDXW + 1,
  localparam int MW   = $clog2(CW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  output logic            req_ready,
  input  logic            alloc_valid,
  input  logic [CW-1:0]   alloc_count,
  input  logic            rel_valid,
  input  logic [IDXW-1:0] rel_base,
  input  logic [MW-1:0]   rel_mask,
  input  logic            mark_valid,
  input  logic [IDXW-1:0] mark_idx,
  output logic            busy,
  output logic            done,
  output logic            fail,
  output logic [IDXW-1:0] res_base,
  output logic [MW-1:0]   res_mask,
  output logic            empty
);
  localparam int EW = IDXW + 2;

  pea_state_t         state;
  logic [EW-1:0]      cand;
  logic [MW-1:0]      cur_mask;
  logic [ENTRIES-1:0] used;

  logic [MW-1:0]      req_mask;
  logic               cnt_zero;
  logic               over_lim;
  logic [ENTRIES-1:0] srch_win;
  logic [ENTRIES-1:0] rel_win;
  logic               hit;
  logic [EW-1:0]      cand_nxt;
  logic               last;
  logic               acc_alloc, acc_rel, acc_mark;

  pea_size_dec #(.CW(CW), .MW(MW)) u_dec (
    .count(alloc_count), .mask(req_mask), .zero(cnt_zero)
  );

  pea_window #(.N(ENTRIES), .EW(EW), .MW(MW)) u_srch_win (
    .base(cand), .mask(cur_mask), .win(srch_win)
  );

  pea_window #(.N(ENTRIES), .EW(EW), .MW(MW)) u_rel_win (
    .base({2'b00, rel_base}), .mask(rel_mask), .win(rel_win)
  );

  assign over_lim  = req_mask > MW'(MAX_MASK);
  assign hit       = ~|(used & srch_win);
  assign cand_nxt  = cand + (EW'(1) << cur_mask);
  assign last      = cand_nxt >= EW'(ENTRIES);
  assign req_ready = (state == ST_IDLE);
  assign busy      = (state == ST_SRCH);
  assign empty     = ~|used;

  assign acc_alloc = req_ready && alloc_valid;
  assign acc_rel   = req_ready && rel_valid && !alloc_valid;
  assign acc_mark  = req_ready && mark_valid && !alloc_valid && !rel_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cand     <= '0;
      cur_mask <= '0;
      used     <= '0;
      done     <= 1'b0;
      fail     <= 1'b0;
      res_base <= '0;
      res_mask <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (acc_alloc) begin
            if (cnt_zero || over_lim) begin
              done     <= 1'b1;
              fail     <= 1'b1;
              res_base <= '0;
              res_mask <= req_mask;
            end else begin
              state    <= ST_SRCH;
              cand     <= '0;
              cur_mask <= req_mask;
            end
          end else if (acc_rel) begin
            used <= used & ~rel_win;
          end else if (acc_mark) begin
            used[mark_idx] <= 1'b1;
          end
        end
        ST_SRCH: begin
          if (hit) begin
            used     <= used | srch_win;
            done     <= 1'b1;
            fail     <= 1'b0;
            res_base <= cand[IDXW-1:0];
            res_mask <= cur_mask;
            state    <= ST_IDLE;
          end else if (last) begin
            done     <= 1'b1;
            fail     <= 1'b1;
            res_base <= '0;
            res_mask <= cur_mask;
            state    <= ST_IDLE;
          end else begin
            cand <= cand_nxt;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  zero_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_alloc && alloc_count == '0) |=> (done && fail && $stable(used)));

  // R3
  lim_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_alloc && over_lim) |=> (done && fail && !busy));

  // R4
  align_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !fail) |-> ((res_base & ((IDXW'(1) << res_mask) - IDXW'(1))) == '0));

  // R8
  nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !fail) |-> !empty);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !hit && !last) |=> (busy && !req_ready && $stable(used)));

  // R6
  rel_chk: assert property (@(posedge clk) disable iff (rst)
    acc_rel |=> ($countones(used) <= $past($countones(used))));
endmodule

// File: tb/pow2_entry_alloc_bench.sv
module pow2_entry_alloc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 32;
  localparam int MAXM = 3;
  localparam int IW   = 5;
  localparam int CW   = 6;
  localparam int MW   = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_ready;
  logic          alloc_valid = 1'b0;
  logic [CW-1:0] alloc_count = '0;
  logic          rel_valid = 1'b0;
  logic [IW-1:0] rel_base = '0;
  logic [MW-1:0] rel_mask = '0;
  logic          mark_valid = 1'b0;
  logic [IW-1:0] mark_idx = '0;
  logic          busy, done, fail, empty;
  logic [IW-1:0] res_base;
  logic [MW-1:0] res_mask;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [N-1:0] mdl = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pow2_entry_alloc #(.ENTRIES(N), .MAX_MASK(MAXM)) u_pow2_entry_alloc (
    .clk(clk), .rst(rst), .req_ready(req_ready),
    .alloc_valid(alloc_valid), .alloc_count(alloc_count),
    .rel_valid(rel_valid), .rel_base(rel_base), .rel_mask(rel_mask),
    .mark_valid(mark_valid), .mark_idx(mark_idx),
    .busy(busy), .done(done), .fail(fail),
    .res_base(res_base), .res_mask(res_mask), .empty(empty)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int size_exp(input int cnt);
    int m = 0;
    int sz = 1;
    while (sz < cnt) begin
      sz = sz * 2;
      m++;
    end
    return m;
  endfunction

  function automatic int lowest_fit(input int m);
    int sz = 1 << m;
    for (int b = 0; b < N; b += sz) begin
      bit free = 1;
      for (int j = b; j < b + sz; j++) if (mdl[j]) free = 0;
      if (free) return b;
    end
    return -1;
  endfunction

  task automatic check_empty(input string req);
    chk(empty == (mdl == '0), req, "empty", int'(empty), int'(mdl == '0));
  endtask

  task automatic run_alloc(input int cnt, input string req);
    int lat = 0;
    int r1 = 1;
    int em, eb;
    @(negedge clk);
    alloc_valid = 1'b1;
    alloc_count = CW'(cnt);
    @(posedge clk);
    #1;
    alloc_valid = 1'b0;
    forever begin
      @(negedge clk);
      lat++;
      if (lat == 1) r1 = int'(req_ready);
      if (done || lat > 200) break;
    end
    chk(done, req, "done seen", int'(done), 1);
    em = size_exp(cnt);
    if (cnt == 0 || em > MAXM) begin
      chk(fail, req, "immediate fail", int'(fail), 1);
      chk(lat == 1, req, "immediate latency", lat, 1);
    end else begin
      eb = lowest_fit(em);
      chk(r1 == 0, "R9", "ready during search", r1, 0);
      if (eb < 0) begin
        chk(fail, req, "no-fit fail", int'(fail), 1);
        chk(lat == (N >> em) + 1, "R5", "scan latency", lat, (N >> em) + 1);
      end else begin
        chk(!fail, req, "fail flag", int'(fail), 0);
        chk(int'(res_base) == eb, req, "base", int'(res_base), eb);
        chk(int'(res_mask) == em, "R2", "mask", int'(res_mask), em);
        chk(lat == (eb >> em) + 2, "R4", "latency", lat, (eb >> em) + 2);
        for (int j = eb; j < eb + (1 << em); j++) mdl[j] = 1'b1;
      end
    end
    check_empty(req);
  endtask

  task automatic do_release(input int b, input int m, input string req);
    @(negedge clk);
    rel_valid = 1'b1;
    rel_base = IW'(b);
    rel_mask = MW'(m);
    @(posedge clk);
    #1;
    rel_valid = 1'b0;
    for (int j = b; j < b + (1 << m) && j < N; j++) mdl[j] = 1'b0;
    @(negedge clk);
    check_empty(req);
  endtask

  task automatic do_mark(input int i, input string req);
    @(negedge clk);
    mark_valid = 1'b1;
    mark_idx = IW'(i);
    @(posedge clk);
    #1;
    mark_valid = 1'b0;
    mdl[i] = 1'b1;
    @(negedge clk);
    check_empty(req);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    chk(empty, "R10", "empty", int'(empty), 1);
    chk(req_ready, "R10", "ready", int'(req_ready), 1);
    chk(!busy, "R10", "busy", int'(busy), 0);
    chk(!done, "R10", "done", int'(done), 0);
  endtask

  task automatic t_basic;
    run_alloc(0, "R1");
    run_alloc(1, "R4");
    run_alloc(3, "R2");
    run_alloc(2, "R4");
    run_alloc(1, "R4");
    run_alloc(5, "R2");
    run_alloc(9, "R3");
  endtask

  task automatic t_preload;
    do_mark(16, "R7");
    run_alloc(8, "R7");
    run_alloc(8, "R5");
    run_alloc(4, "R4");
  endtask

  task automatic t_release;
    do_release(8, 3, "R6");
    run_alloc(8, "R6");
    do_release(4, 2, "R6");
    run_alloc(2, "R6");
    run_alloc(1, "R6");
    do_release(0, 5, "R8");
    do_mark(3, "R8");
    do_release(3, 0, "R8");
  endtask

  task automatic t_priority;
    @(negedge clk);
    rel_valid = 1'b1;
    rel_base = '0;
    rel_mask = '0;
    mark_valid = 1'b1;
    mark_idx = IW'(3);
    @(posedge clk);
    #1;
    rel_valid = 1'b0;
    mark_valid = 1'b0;
    @(negedge clk);
    chk(empty, "R11", "mark dropped under release", int'(empty), 1);
    @(negedge clk);
    mark_valid = 1'b1;
    mark_idx = IW'(5);
    alloc_valid = 1'b1;
    alloc_count = CW'(1);
    @(posedge clk);
    #1;
    mark_valid = 1'b0;
    alloc_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(int'(res_base) == 0 && !fail, "R11", "alloc won", int'(res_base), 0);
    mdl[0] = 1'b1;
    do_release(0, 0, "R11");
    chk(empty, "R11", "mark dropped under alloc", int'(empty), 1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_preload();
    t_release();
    t_priority();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule